// File: doc/BRIEF.md
# Debounced GPIO Port with Edge Interrupts and Key Reset

This block controls one 8-bit bank of general-purpose pins. Each pin has its own settings for output data, output enable, input enable and pull-up request. A per-pin function-select bit hands the pad to an on-chip peripheral instead of the register path. Every pad input passes through a two-flop synchroniser and then a per-port glitch filter that runs on the block clock. The filtered levels feed the input register, the edge-interrupt logic and a key-combination reset detector.

Software sees a small register bank. The bus write strobe, address and data are plain control pins, and the read data is a combinational function of the address. Nothing in the block streams data, so there is no handshake and no back-pressure. Interrupt flags are sticky and are cleared by writing 1. A configurable group of pins raises a one-cycle reset request once all of them have been held low for long enough.

Top module: `gpio_port`

## Requirements
- R1: After a synchronous active-low reset, the registers read back as follows: output data 0x00, output enable 0x00, input enable 0xFF, pull-up 0x00, function select 0x00, edge select 0x00, mask 0x00, flags 0x00, filter setting 0, key select 0x00. Both `irq` and `key_rst_req` are 0. The register addresses are: 0 data out, 1 output enable, 2 input enable, 3 pull-up, 4 function select, 5 edge select, 6 mask, 7 flags, 8 filter setting (bits 2:0), 9 key select, 10 input (read only).
- R2: When a pin's function-select bit is 0, `pad_out` follows its data-out bit and `pad_oe` follows its output-enable bit. `pad_pu` always equals the pull-up register.
- R3: When a pin's function-select bit is 1, `pad_out` and `pad_oe` follow `per_out` and `per_oe` for that pin. `per_in` carries the synchronised pad level ANDed with input enable, two clock edges after the pad changes.
- R4: The input register reads the filtered pin level ANDed with input enable. With the filter setting at 0, a pad change shows on the third rising edge after it is driven.
- R5: With a filter setting N from 1 to 7, a changed synchronised level is accepted only after it has stayed the same for 2^(N+1) clock cycles. A shorter pulse is discarded.
- R6: An edge-select bit of 0 selects the rising edge and 1 selects the falling edge. The pin's flag is set one clock after the filtered level makes the selected transition. The opposite transition sets nothing.
- R7: Writing 1 to a flag bit clears that bit. Writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some flag bit is set whose mask bit is also 1.
- R9: A pin whose input-enable bit is 0 reads 0 in the input register and never sets its flag.
- R10: When every pin in a non-empty key selection has been filtered low for 4 consecutive cycles, `key_rst_req` pulses for exactly one cycle. It does not pulse again until the condition has been broken.
- R11: An all-zero key selection never raises `key_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; also runs the filters |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output-drive enable |
| pad_pu | output | 8 | Pull-up request to the pad cells |
| per_out | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral drive enables |
| per_in | output | 8 | Synchronised, input-gated pad levels to peripherals |
| irq | output | 1 | Masked interrupt |
| key_rst_req | output | 1 | One-cycle key-combination reset request |

## Verification
The pad multiplexing and the pull-up request are combinational from the registers. They are checked a moment after the write edge. `per_in` lands two edges after a pad change. The input register lands three edges after it with the filter bypassed, and 2^(N+1)+2 edges after it with setting N. A flag follows one edge after the input register, and the key request follows four edges after the selected pins go low in the filtered view. The bench drives pads on falling clock edges and counts falling edges up to the due cycle. It samples one edge early to confirm the old value and then on the due edge to confirm the new one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [3:0] {
    A_DOUT  = 4'd0,
    A_OEN   = 4'd1,
    A_IEN   = 4'd2,
    A_PUEN  = 4'd3,
    A_FSEL  = 4'd4,
    A_EDGE  = 4'd5,
    A_MASK  = 4'd6,
    A_FLAG  = 4'd7,
    A_FILT  = 4'd8,
    A_KSEL  = 4'd9,
    A_PIN   = 4'd10
  } gpio_addr_e;
endpackage

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_async,
  input  logic [CFG_W-1:0] cfg,
  output logic             sync_o,
  output logic             filt_o
);
  localparam int CNT_W = 2 ** CFG_W;

  logic             meta_q, sync_q, filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim;

  always_comb begin
    if (cfg == '0) lim = '0;
    else lim = ({{CNT_W{1'b0}}, 1'b1} << (int'(cfg) + 1)) - {{CNT_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      if (sync_q == filt_q) begin
        cnt_q <= '0;
      end else if ({1'b0, cnt_q} == lim) begin
        filt_q <= sync_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sync_o = sync_q;
  assign filt_o = filt_q;

  AST_FILT_TAKES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> filt_q == $past(sync_q)); // R5
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] filt,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] mask,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] filt_d, flags_q, hit, clr;

  assign hit = ien & (filt ^ filt_d) & (fall_sel ^ filt);
  assign clr = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_d  <= '1;
      flags_q <= '0;
    end else begin
      filt_d  <= filt;
      flags_q <= (flags_q & ~clr) | hit;
    end
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & mask);

  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(hit)) == '0)); // R6
  AST_FLAG_NO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(ien)) == '0)); // R9
endmodule

// File: rtl/gpio_key_rst.sv
module gpio_key_rst #(
  parameter int W    = 8,
  parameter int HOLD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] filt,
  input  logic [W-1:0] sel,
  output logic         req
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] TOP  = CW'(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          cond, req_q;
  logic [CW-1:0] cnt_q;

  assign cond = (sel != '0) && ((filt & sel) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= cond && (cnt_q == LAST);
      if (!cond) cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req = req_q;

  AST_KRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R10
  AST_KRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(cond)); // R10
  AST_KRST_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(sel != '0)); // R11
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W     = 8,
  parameter int CFG_W = 3,
  parameter int HOLD  = 4,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  input  logic [W-1:0]  per_out,
  input  logic [W-1:0]  per_oe,
  output logic [W-1:0]  per_in,
  output logic          irq,
  output logic          key_rst_req
);
  logic [W-1:0]     dout_q, oen_q, ien_q, pu_q, fsel_q, edge_q, mask_q, ksel_q;
  logic [CFG_W-1:0] filt_cfg_q;
  logic [W-1:0]     sync_v, filt_v, flags;
  gpio_addr_e       addr;

  assign addr = gpio_addr_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q     <= '0;
      oen_q      <= '0;
      ien_q      <= '1;
      pu_q       <= '0;
      fsel_q     <= '0;
      edge_q     <= '0;
      mask_q     <= '0;
      ksel_q     <= '0;
      filt_cfg_q <= '0;
    end else if (reg_we) begin
      case (addr)
        A_DOUT: dout_q     <= reg_wdata;
        A_OEN:  oen_q      <= reg_wdata;
        A_IEN:  ien_q      <= reg_wdata;
        A_PUEN: pu_q       <= reg_wdata;
        A_FSEL: fsel_q     <= reg_wdata;
        A_EDGE: edge_q     <= reg_wdata;
        A_MASK: mask_q     <= reg_wdata;
        A_KSEL: ksel_q     <= reg_wdata;
        A_FILT: filt_cfg_q <= reg_wdata[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_in_filter #(.CFG_W(CFG_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_async(pad_in[i]), .cfg(filt_cfg_q),
      .sync_o(sync_v[i]), .filt_o(filt_v[i])
    );
    assign pad_out[i] = fsel_q[i] ? per_out[i] : dout_q[i];
    assign pad_oe[i]  = fsel_q[i] ? per_oe[i]  : oen_q[i];
  end

  assign pad_pu = pu_q;
  assign per_in = sync_v & ien_q;

  gpio_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .filt(filt_v), .ien(ien_q), .fall_sel(edge_q),
    .mask(mask_q), .clr_we(reg_we && addr == A_FLAG), .clr_bits(reg_wdata),
    .flags(flags), .irq(irq)
  );

  gpio_key_rst #(.W(W), .HOLD(HOLD)) u_key (
    .clk(clk), .rst_n(rst_n), .filt(filt_v), .sel(ksel_q), .req(key_rst_req)
  );

  always_comb begin
    case (addr)
      A_DOUT:  reg_rdata = dout_q;
      A_OEN:   reg_rdata = oen_q;
      A_IEN:   reg_rdata = ien_q;
      A_PUEN:  reg_rdata = pu_q;
      A_FSEL:  reg_rdata = fsel_q;
      A_EDGE:  reg_rdata = edge_q;
      A_MASK:  reg_rdata = mask_q;
      A_FLAG:  reg_rdata = flags;
      A_FILT:  reg_rdata = W'(filt_cfg_q);
      A_KSEL:  reg_rdata = ksel_q;
      A_PIN:   reg_rdata = filt_v & ien_q;
      default: reg_rdata = '0;
    endcase
  end

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0)); // R8
  AST_PU_TRACKS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && addr == A_PUEN) |=> pad_pu == $past(reg_wdata)); // R2
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, pad_out, pad_oe, pad_pu, per_in;
  logic [7:0] pad_in = 8'hFF, per_out = '0, per_oe = '0;
  logic       irq, key_rst_req;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .per_out(per_out),
    .per_oe(per_oe), .per_in(per_in), .irq(irq), .key_rst_req(key_rst_req)
  );

  // {dout, oen, fsel, per_out, per_oe, exp pad_out, exp pad_oe}
  localparam logic [55:0] VEC [4] = '{
    56'hA5_FF_00_3C_0F_A5_FF,
    56'hA5_0F_FF_3C_F0_3C_F0,
    56'hF0_33_0F_55_CC_F5_3C,
    56'h00_FF_AA_FF_00_AA_55
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(40000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first, cnt;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 oen", 4'd1, 8'h00);
    rd("R1 ien", 4'd2, 8'hFF);
    rd("R1 pu", 4'd3, 8'h00);
    rd("R1 fsel", 4'd4, 8'h00);
    rd("R1 flags", 4'd7, 8'h00);
    rd("R1 ksel", 4'd9, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 krst", {7'd0, key_rst_req}, 8'h00);

    wr(4'd3, 8'h5A);
    #0.5 chk("R2 pad_pu", pad_pu, 8'h5A);

    for (int i = 0; i < 4; i++) begin
      wr(4'd0, VEC[i][55:48]);
      wr(4'd1, VEC[i][47:40]);
      wr(4'd4, VEC[i][39:32]);
      per_out = VEC[i][31:24];
      per_oe  = VEC[i][23:16];
      #0.5;
      chk("R2/R3 pad_out", pad_out, VEC[i][15:8]);
      chk("R2/R3 pad_oe", pad_oe, VEC[i][7:0]);
    end
    wr(4'd4, 8'h00);
    wr(4'd1, 8'h00);

    // R3 peripheral input path
    pad_in = 8'h0F;
    cyc(1); chk("R3 per_in early", per_in, 8'hFF);
    cyc(1); chk("R3 per_in", per_in, 8'h0F);
    pad_in = 8'hFF; cyc(6);

    wr(4'd7, 8'hFF);
    wr(4'd6, 8'hFF);
    wr(4'd5, 8'h01);
    pad_in = 8'hFE;
    cyc(2); rd("R4 in early", 4'd10, 8'hFF);
    cyc(1); rd("R4 in", 4'd10, 8'hFE);
    rd("R6 flag early", 4'd7, 8'h00);
    cyc(1); rd("R6 falling flag", 4'd7, 8'h01);
    chk("R8 irq on", {7'd0, irq}, 8'h01);
    wr(4'd6, 8'h00);
    #0.5 chk("R8 irq masked", {7'd0, irq}, 8'h00);
    wr(4'd6, 8'hFF);
    wr(4'd7, 8'h00);
    rd("R7 write0 keeps", 4'd7, 8'h01);
    wr(4'd7, 8'h01);
    rd("R7 write1 clears", 4'd7, 8'h00);
    #0.5 chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    pad_in = 8'hFF; cyc(6);
    rd("R6 opposite edge", 4'd7, 8'h00);

    // R9 input disable
    wr(4'd2, 8'hFE);
    rd("R9 in gated", 4'd10, 8'hFE);
    pad_in = 8'hFE; cyc(6);
    rd("R9 no flag", 4'd7, 8'h00);
    pad_in = 8'hFF; cyc(6);
    wr(4'd2, 8'hFF);
    rd("R9 restored", 4'd7, 8'h00);

    // R5 filter setting 1 -> 4 stable cycles
    wr(4'd8, 8'h01);
    pad_in = 8'hFD;
    cyc(5); rd("R5 before accept", 4'd10, 8'hFF);
    cyc(1); rd("R5 accepted", 4'd10, 8'hFD);
    pad_in = 8'hFF; cyc(10);
    wr(4'd7, 8'hFF);
    pad_in = 8'hFD; cyc(3);
    pad_in = 8'hFF; cyc(10);
    rd("R5 glitch rejected", 4'd10, 8'hFF);
    rd("R5 glitch no flag", 4'd7, 8'h00);
    wr(4'd8, 8'h00);

    // R10 key reset
    wr(4'd9, 8'h03);
    pad_in = 8'hFC;
    first = 0; cnt = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (key_rst_req) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    chk("R10 pulse cycle", 8'(first), 8'd7);
    chk("R10 single pulse", 8'(cnt), 8'd1);
    pad_in = 8'hFF; cyc(6);

    // R11 empty selection
    wr(4'd9, 8'h00);
    pad_in = 8'h00;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (key_rst_req) cnt++;
    end
    chk("R11 no pulse", 8'(cnt), 8'd0);
    pad_in = 8'hFF; cyc(6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule